// File: doc/BRIEF.md
# One-Operand Shift and Byte Unit

This unit covers the one-operand register instructions of a 16-bit processor. It decodes an instruction word and works on the value of the destination register. It can rotate right through the carry, shift right arithmetically, swap the two bytes, or sign-extend the low byte. It returns the new register value, a write strobe, the destination register index and the updated status flags.

Results appear one clock after the request. Three instruction groups share this encoding space: the stack-push, subroutine-call and interrupt-return groups. The unit does not execute them. It only raises a hand-off flag, so that the surrounding core can route them to its stack and sequencing logic.

Operand fetch through the addressing-mode field is left to the caller. The caller supplies the value that the mode selects, and the unit ignores the mode bits.

Top module: `so_unit`

## Requirements
- R1: `out_valid` equals the `in_valid` of the previous clock. The outputs on a valid cycle describe the instruction presented one clock earlier.
- R2: An instruction word with bits 15:10 = 000100 and bits 9:7 in {4, 5, 6} is handed off, whatever bit 6 holds. Examples are 0x1200, 0x1240, 0x1280 and 0x1300. For a handed-off word `pass_up` = 1 and `wr_en` = 0, the flags are copied from the inputs, and `result` equals the operand.
- R3: Any word that is neither executed nor handed off gives `wr_en` = 0 and `pass_up` = 0, flags equal to the inputs, and `result` equal to the operand. Such words include: words outside the 000100 group, bits 9:7 = 7, and the swap or extend code with bit 6 set.
- R4: Word rotate (bits 9:7 = 0, bit 6 = 0): the result is the operand shifted right by one, with the old C placed in bit 15. The new C is the old bit 0.
- R5: Byte mode (bit 6 = 1) of the rotate and of the arithmetic shift works on bits 7:0 only. Bit 7 takes the role of the MSB, bits 15:8 of the result are zero, and N and Z are taken from the low byte.
- R6: Word arithmetic shift (bits 9:7 = 2, bit 6 = 0): the result is the operand shifted right by one with bit 15 kept. The new C is the old bit 0.
- R7: For the rotate, V = 1 exactly when the operand MSB (bit 15, or bit 7 in byte mode) is 1 and the incoming C is 1. N is the result MSB and Z flags a zero result.
- R8: The arithmetic shift always clears V. N and Z follow the result.
- R9: Byte swap (bits 9:7 = 1, bit 6 = 0) exchanges bits 15:8 and bits 7:0. All four flags pass through unchanged.
- R10: Sign extend (bits 9:7 = 3, bit 6 = 0) copies bit 7 into bits 15:8. N = bit 15 and Z flags a zero result. C = NOT Z and V = 0.
- R11: While `rst_n` is low, `out_valid`, `wr_en`, `pass_up`, `result`, `dst_reg` and all flag outputs are 0.
- R12: `dst_reg` is bits 3:0 of the instruction. The addressing-mode bits 5:4 have no effect on the result or the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| instr | input | 16 | Instruction word |
| operand | input | DATA_W | Destination register value |
| c_in | input | 1 | Carry flag in |
| z_in | input | 1 | Zero flag in |
| n_in | input | 1 | Negative flag in |
| v_in | input | 1 | Overflow flag in |
| out_valid | output | 1 | Result strobe |
| result | output | DATA_W | New register value |
| wr_en | output | 1 | Register write strobe |
| pass_up | output | 1 | Instruction handed to other logic |
| dst_reg | output | 4 | Destination register index |
| c_out | output | 1 | Carry flag out |
| z_out | output | 1 | Zero flag out |
| n_out | output | 1 | Negative flag out |
| v_out | output | 1 | Overflow flag out |

## Verification
The following properties are checked on every cycle:
- the one-clock latency of the strobe;
- that a hand-off never writes;
- that every non-writing cycle returns the incoming flags;
- that a swap returns the exchanged bytes;
- that byte-mode writes leave the upper byte zero;
- the fixed V and C rules of the arithmetic shift and the sign extend.

Only the bench scenarios can show the exact bits that the rotate and the shifts produce. The same holds for the rotate's V rule, for byte-wise Z, for the zero and negative edge cases, and for the reset values.

// File: rtl/so_pkg.sv
package so_pkg;
   localparam int INSTR_W   = 16;
   localparam int REG_IDX_W = 4;
   localparam logic [5:0] GROUP_TAG = 6'b000100;

   typedef enum logic [2:0] {
      OP_RRC  = 3'd0,
      OP_SWP  = 3'd1,
      OP_RRA  = 3'd2,
      OP_SXT  = 3'd3,
      OP_PASS = 3'd4,
      OP_NONE = 3'd5
   } so_op_e;

   typedef struct packed {
      logic v;
      logic n;
      logic z;
      logic c;
   } so_flags_t;
endpackage

// File: rtl/so_decode.sv
module so_decode
   import so_pkg::*;
(
   input  logic [INSTR_W-1:0]   instr,
   output so_op_e               op,
   output logic                 byte_sel,
   output logic [REG_IDX_W-1:0] dst
);
   logic bw;
   logic [1:0] unused_mode;

   assign bw          = instr[6];
   assign unused_mode = instr[5:4];
   assign dst         = instr[REG_IDX_W-1:0];
   assign byte_sel    = bw;

   always_comb begin
      op = OP_NONE;
      if (instr[15:10] == GROUP_TAG) begin
         case (instr[9:7])
            3'd0:    op = OP_RRC;
            3'd1:    op = bw ? OP_NONE : OP_SWP;
            3'd2:    op = OP_RRA;
            3'd3:    op = bw ? OP_NONE : OP_SXT;
            3'd4,
            3'd5,
            3'd6:    op = OP_PASS;
            default: op = OP_NONE;
         endcase
      end
   end
endmodule

// File: rtl/so_shift.sv
module so_shift #(
   parameter int DATA_W = 16
) (
   input  logic [DATA_W-1:0] operand,
   input  logic              c_in,
   input  logic              arith,
   input  logic              byte_sel,
   output logic [DATA_W-1:0] res,
   output logic              c_out,
   output logic              v_out,
   output logic              n_out,
   output logic              z_out
);
   localparam int BYTE_W = DATA_W / 2;

   logic              msb_w, msb_b, fill;
   logic [DATA_W-1:0] word_res, byte_res;

   assign msb_w = operand[DATA_W-1];
   assign msb_b = operand[BYTE_W-1];
   assign fill  = arith ? (byte_sel ? msb_b : msb_w) : c_in;

   // bit-level mapping, one generate per half
   for (genvar i = 0; i < DATA_W; i++) begin : g_word
      if (i == DATA_W-1) begin : g_top
         assign word_res[i] = fill;
      end else begin : g_mid
         assign word_res[i] = operand[i+1];
      end
   end

   for (genvar j = 0; j < DATA_W; j++) begin : g_byte
      if (j >= BYTE_W) begin : g_hi
         assign byte_res[j] = 1'b0;
      end else if (j == BYTE_W-1) begin : g_top
         assign byte_res[j] = fill;
      end else begin : g_mid
         assign byte_res[j] = operand[j+1];
      end
   end

   assign res   = byte_sel ? byte_res : word_res;
   assign c_out = operand[0];
   assign v_out = arith ? 1'b0 : ((byte_sel ? msb_b : msb_w) & c_in);
   assign n_out = byte_sel ? res[BYTE_W-1] : res[DATA_W-1];
   assign z_out = byte_sel ? (res[BYTE_W-1:0] == '0) : (res == '0);
endmodule

// File: rtl/so_bytes.sv
module so_bytes #(
   parameter int DATA_W = 16
) (
   input  logic [DATA_W-1:0] operand,
   output logic [DATA_W-1:0] swapped,
   output logic [DATA_W-1:0] extended,
   output logic              ext_n,
   output logic              ext_z
);
   localparam int BYTE_W = DATA_W / 2;

   assign swapped = {operand[BYTE_W-1:0], operand[DATA_W-1:BYTE_W]};

   for (genvar i = 0; i < DATA_W; i++) begin : g_ext
      if (i < BYTE_W) begin : g_lo
         assign extended[i] = operand[i];
      end else begin : g_hi
         assign extended[i] = operand[BYTE_W-1];
      end
   end

   assign ext_n = extended[DATA_W-1];
   assign ext_z = (extended == '0);
endmodule

// File: rtl/so_unit.sv
module so_unit
   import so_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [15:0]       instr,
   input  logic [DATA_W-1:0] operand,
   input  logic              c_in,
   input  logic              z_in,
   input  logic              n_in,
   input  logic              v_in,
   output logic              out_valid,
   output logic [DATA_W-1:0] result,
   output logic              wr_en,
   output logic              pass_up,
   output logic [3:0]        dst_reg,
   output logic              c_out,
   output logic              z_out,
   output logic              n_out,
   output logic              v_out
);
   if ((DATA_W % 2) != 0 || DATA_W < 4) begin : g_bad_width
      $error("so_unit: DATA_W must be even and at least 4");
   end

   so_op_e               op;
   logic                 byte_sel;
   logic [REG_IDX_W-1:0] dst;
   so_flags_t            f_in, f_nxt, f_q;
   logic [DATA_W-1:0]    sh_res, swp_res, ext_res, res_nxt;
   logic                 sh_c, sh_v, sh_n, sh_z, ext_n, ext_z;
   logic                 wr_nxt, pass_nxt;

   assign f_in = '{v: v_in, n: n_in, z: z_in, c: c_in};

   so_decode u_dec (
      .instr    (instr),
      .op       (op),
      .byte_sel (byte_sel),
      .dst      (dst)
   );

   so_shift #(.DATA_W(DATA_W)) u_sh (
      .operand  (operand),
      .c_in     (c_in),
      .arith    (op == OP_RRA),
      .byte_sel (byte_sel),
      .res      (sh_res),
      .c_out    (sh_c),
      .v_out    (sh_v),
      .n_out    (sh_n),
      .z_out    (sh_z)
   );

   so_bytes #(.DATA_W(DATA_W)) u_by (
      .operand  (operand),
      .swapped  (swp_res),
      .extended (ext_res),
      .ext_n    (ext_n),
      .ext_z    (ext_z)
   );

   always_comb begin
      res_nxt  = operand;
      f_nxt    = f_in;
      wr_nxt   = 1'b0;
      pass_nxt = 1'b0;
      case (op)
         OP_RRC, OP_RRA: begin
            res_nxt = sh_res;
            f_nxt   = '{v: sh_v, n: sh_n, z: sh_z, c: sh_c};
            wr_nxt  = 1'b1;
         end
         OP_SWP: begin
            res_nxt = swp_res;
            wr_nxt  = 1'b1;
         end
         OP_SXT: begin
            res_nxt = ext_res;
            f_nxt   = '{v: 1'b0, n: ext_n, z: ext_z, c: ~ext_z};
            wr_nxt  = 1'b1;
         end
         OP_PASS: pass_nxt = 1'b1;
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
         wr_en     <= 1'b0;
         pass_up   <= 1'b0;
         dst_reg   <= '0;
         f_q       <= '0;
      end else begin
         out_valid <= in_valid;
         result    <= res_nxt;
         wr_en     <= in_valid & wr_nxt;
         pass_up   <= in_valid & pass_nxt;
         dst_reg   <= dst;
         f_q       <= f_nxt;
      end
   end

   assign c_out = f_q.c;
   assign z_out = f_q.z;
   assign n_out = f_q.n;
   assign v_out = f_q.v;
endmodule

// File: rtl/so_unit_chk.sv
module so_unit_chk #(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [15:0]       instr,
   input logic [DATA_W-1:0] operand,
   input logic              c_in,
   input logic              z_in,
   input logic              n_in,
   input logic              v_in,
   input logic              out_valid,
   input logic [DATA_W-1:0] result,
   input logic              wr_en,
   input logic              pass_up,
   input logic              c_out,
   input logic              z_out,
   input logic              n_out,
   input logic              v_out
);
   localparam int BYTE_W = DATA_W / 2;

   a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r1_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   a_r2_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      pass_up |-> !wr_en);
   a_r3_flags_kept: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (wr_en || ({v_out, n_out, z_out, c_out} ==
                    {$past(v_in), $past(n_in), $past(z_in), $past(c_in)})));
   a_r5_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && instr[15:10] == 6'b000100 && instr[6] && !instr[7] && !instr[9])
      |=> (result[DATA_W-1:BYTE_W] == '0));
   a_r8_rra_no_v: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && instr[15:7] == 9'h022) |=> !v_out);
   a_r9_swap: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && instr[15:6] == 10'h042)
      |=> (result == {$past(operand[BYTE_W-1:0]), $past(operand[DATA_W-1:BYTE_W])}));
   a_r10_sxt_cv: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && instr[15:6] == 10'h046) |=> (c_out == !z_out && !v_out));
endmodule

bind so_unit so_unit_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .instr     (instr),
   .operand   (operand),
   .c_in      (c_in),
   .z_in      (z_in),
   .n_in      (n_in),
   .v_in      (v_in),
   .out_valid (out_valid),
   .result    (result),
   .wr_en     (wr_en),
   .pass_up   (pass_up),
   .c_out     (c_out),
   .z_out     (z_out),
   .n_out     (n_out),
   .v_out     (v_out)
);

// File: tb/sim_so_unit.sv
`timescale 1ns/1ps
module sim_so_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [15:0] instr = '0;
   logic [15:0] operand = '0;
   logic        c_in = 1'b0, z_in = 1'b0, n_in = 1'b0, v_in = 1'b0;
   logic        out_valid, wr_en, pass_up, c_out, z_out, n_out, v_out;
   logic [15:0] result;
   logic [3:0]  dst_reg;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   so_unit #(.DATA_W(16)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
      .operand(operand), .c_in(c_in), .z_in(z_in), .n_in(n_in), .v_in(v_in),
      .out_valid(out_valid), .result(result), .wr_en(wr_en), .pass_up(pass_up),
      .dst_reg(dst_reg), .c_out(c_out), .z_out(z_out), .n_out(n_out), .v_out(v_out)
   );

   // {instr, operand, flags in {v,n,z,c}, result, flags out, wr_en, pass_up}
   localparam int NV = 20;
   localparam logic [57:0] VEC [0:NV-1] = '{
      {16'h1005, 16'h0001, 4'b0001, 16'h8000, 4'b0101, 1'b1, 1'b0},
      {16'h1000, 16'h8002, 4'b0001, 16'hC001, 4'b1100, 1'b1, 1'b0},
      {16'h1000, 16'h0001, 4'b0000, 16'h0000, 4'b0011, 1'b1, 1'b0},
      {16'h1040, 16'hFF81, 4'b0001, 16'h00C0, 4'b1101, 1'b1, 1'b0},
      {16'h1100, 16'h8003, 4'b1111, 16'hC001, 4'b0101, 1'b1, 1'b0},
      {16'h1100, 16'h0001, 4'b0000, 16'h0000, 4'b0011, 1'b1, 1'b0},
      {16'h1140, 16'h12F0, 4'b0000, 16'h00F8, 4'b0100, 1'b1, 1'b0},
      {16'h1080, 16'h12AB, 4'b1010, 16'hAB12, 4'b1010, 1'b1, 1'b0},
      {16'h1180, 16'h0080, 4'b0000, 16'hFF80, 4'b0101, 1'b1, 1'b0},
      {16'h1180, 16'hFF7F, 4'b1111, 16'h007F, 4'b0001, 1'b1, 1'b0},
      {16'h1180, 16'hAB00, 4'b0000, 16'h0000, 4'b0010, 1'b1, 1'b0},
      {16'h1200, 16'h1234, 4'b1001, 16'h1234, 4'b1001, 1'b0, 1'b1},
      {16'h1280, 16'h5555, 4'b0110, 16'h5555, 4'b0110, 1'b0, 1'b1},
      {16'h1300, 16'h00FF, 4'b0000, 16'h00FF, 4'b0000, 1'b0, 1'b1},
      {16'h1240, 16'h8001, 4'b1111, 16'h8001, 4'b1111, 1'b0, 1'b1},
      {16'h4000, 16'h0F0F, 4'b0011, 16'h0F0F, 4'b0011, 1'b0, 1'b0},
      {16'h1380, 16'h7777, 4'b0101, 16'h7777, 4'b0101, 1'b0, 1'b0},
      {16'h10C0, 16'h12AB, 4'b0000, 16'h12AB, 4'b0000, 1'b0, 1'b0},
      {16'h1035, 16'h0002, 4'b0000, 16'h0001, 4'b0000, 1'b1, 1'b0},
      {16'h1040, 16'hFF00, 4'b0000, 16'h0000, 4'b0010, 1'b1, 1'b0}
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic string tag_of(input logic [15:0] w);
      if (w[15:10] != 6'b000100) return "R3";
      case (w[9:7])
         3'd0: return w[6] ? "R5/R7" : "R4/R7";
         3'd1: return w[6] ? "R3" : "R9";
         3'd2: return w[6] ? "R5/R8" : "R6/R8";
         3'd3: return w[6] ? "R3" : "R10";
         3'd7: return "R3";
         default: return "R2";
      endcase
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(20000 * 5);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      // R11: reset state with a request pending
      in_valid = 1'b1; instr = 16'h1180; operand = 16'h0080;
      {v_in, n_in, z_in, c_in} = 4'b1111;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R11 reset ctrl", {28'd0, out_valid, wr_en, pass_up, 1'b0}, 32'd0);
      check("R11 reset data", {12'd0, result, dst_reg}, 32'd0);
      check("R11 reset flags", {28'd0, v_out, n_out, z_out, c_out}, 32'd0);
      rst_n = 1'b1; in_valid = 1'b0;
      @(negedge clk);

      for (int k = 0; k < NV; k++) begin
         logic [57:0] e;
         string t;
         e = VEC[k];
         t = tag_of(e[57:42]);
         instr = e[57:42]; operand = e[41:26];
         {v_in, n_in, z_in, c_in} = e[25:22];
         in_valid = 1'b1;
         @(negedge clk);
         check({t, " result"}, {16'd0, result}, {16'd0, e[21:6]});
         check({t, " flags"}, {28'd0, v_out, n_out, z_out, c_out}, {28'd0, e[5:2]});
         check({t, " wr/pass"}, {30'd0, wr_en, pass_up}, {30'd0, e[1:0]});
         check("R12 dst_reg", {28'd0, dst_reg}, {28'd0, e[45:42]});
         check("R1 out_valid", {31'd0, out_valid}, 32'd1);
      end

      // R1: idle request leaves no strobes
      in_valid = 1'b0;
      @(negedge clk);
      check("R1 idle", {29'd0, out_valid, wr_en, pass_up}, 32'd0);

      // R12: mode bits do not change a byte rotate
      instr = 16'h1070; operand = 16'hFF81; {v_in, n_in, z_in, c_in} = 4'b0001;
      in_valid = 1'b1;
      @(negedge clk);
      check("R12 mode ignored", {12'd0, result, v_out, n_out, z_out, c_out},
            {12'd0, 16'h00C0, 4'b1101});
      check("R12 dst 0", {28'd0, dst_reg}, 32'd0);

      // R7: negative operand with C clear gives V = 0
      instr = 16'h100F; operand = 16'h8000; {v_in, n_in, z_in, c_in} = 4'b0000;
      @(negedge clk);
      check("R7 no V", {12'd0, result, v_out, n_out, z_out, c_out},
            {12'd0, 16'h4000, 4'b0000});

      // R11: reset in mid-run clears outputs
      rst_n = 1'b0;
      @(negedge clk);
      check("R11 mid reset", {27'd0, out_valid, wr_en, pass_up, v_out, c_out}, 32'd0);
      rst_n = 1'b1; in_valid = 1'b0;
      @(negedge clk);
      finish_run();
   end
endmodule